// File: doc/BRIEF.md
# Converter Sample FIFO with Swing Playback

This block sits in front of a digital-to-analog converter's data latch. Software writes samples through a single write port, and the block presents one sample at a time on its output register, `conv_data`. Each trigger moves the output to the next sample. A trigger comes either from a hardware input pulse or from a software strobe, and a select input chooses which of the two is used. Three playback modes exist. Buffer mode bypasses the FIFO entirely. Normal mode drains the FIFO oldest-first. Swing mode keeps the stored samples and sweeps a read index up to the newest entry and back down to the oldest, over and over, which gives triangle-order playback.

The block keeps status flags. Full, empty and watermark are live levels. Underflow, overflow and swing-complete are sticky and are cleared by writing a one to their bit. Each flag has an interrupt enable, and these combine into one interrupt line. Two request outputs ask a DMA engine for more data: one on empty and one on watermark. A FIFO-pointer reset input and a full soft reset input are synchronous. The active-low `rst_n` is asynchronous.

In swing mode, a small two-state sequencer moves the read index. In state SW_RISE, each trigger raises the index. On reaching the top, the index steps down. The sequencer then goes to SW_FALL, or it stays in SW_RISE if the step down lands on zero. In state SW_FALL, each trigger lowers the index. When the index reaches zero, the sequencer returns to SW_RISE and flags a completed period. Any reset, or leaving swing mode, forces SW_RISE with index zero.

Top module: `dac_sample_fifo`

## Requirements
- R1: With `mode`=0 (buffer), a write sets `conv_data` to the written value on the next clock. Triggers in this mode change no output and leave the FIFO untouched.
- R2: With `mode`=1 or 3 (normal), a trigger when the FIFO is not empty loads the oldest stored entry into `conv_data` on the next clock and removes that entry. Entries leave in write order.
- R3: A trigger in normal or swing mode while the FIFO is empty sets `uf_flag` and leaves `conv_data` and the pointers unchanged.
- R4: A write in normal or swing mode while the FIFO holds DEPTH entries sets `of_flag` and discards the data. The stored entries are unchanged.
- R5: Outside swing mode, `wm_flag` is 1 whenever the entry count after the clock is at or below `wm_level` (0..DEPTH). It drops once writes lift the count above `wm_level`. `empty_flag` shows count 0 and `full_flag` shows count DEPTH, with the same timing.
- R6: With `mode`=2 (swing) and N entries stored, successive triggers load the entries at index 0,1,..,N-1,N-2,..,1,0,1,... counted from the oldest. `swbk_flag` sets on the trigger that brings the index back to 0, which is the 4th trigger for N=3. With N=1, every trigger loads index 0 and sets `swbk_flag`.
- R7: While `mode`=2, `empty_flag`, `full_flag` and `wm_flag` hold their values, even when writes change the count.
- R8: `uf_flag`, `of_flag` and `swbk_flag` stay set until a clock where `flag_clr` bit 0, bit 1 or bit 2, respectively, is 1. A set event in the same clock wins over the clear.
- R9: With `trig_sel`=0, only `hw_trig` triggers. With `trig_sel`=1, only `sw_trig` triggers, and the other input has no effect.
- R10: `fifo_rst` empties the FIFO, returns the swing sequencer to index 0, clears the sticky flags, and sets empty=1, full=0, watermark=1. It leaves `conv_data` unchanged. `soft_rst` takes priority over it.
- R11: `soft_rst` and `rst_n` do everything `fifo_rst` does and also clear `conv_data` to 0.
- R12: `irq` is the OR of flag AND enable, using this `int_en` bit order: 0 full, 1 empty, 2 watermark, 3 swing-complete, 4 overflow, 5 underflow. `dma_empty_req` is `empty_flag & dma_en[0]` and `dma_wm_req` is `wm_flag & dma_en[1]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_rst | input | 1 | Synchronous full reset |
| fifo_rst | input | 1 | Synchronous FIFO pointer and flag reset |
| mode | input | 2 | 0 buffer, 1/3 normal, 2 swing |
| trig_sel | input | 1 | 0 hardware trigger, 1 software trigger |
| hw_trig | input | 1 | Hardware trigger pulse |
| sw_trig | input | 1 | Software trigger strobe |
| wr_en | input | 1 | Data write strobe |
| wr_data | input | DATA_W | Data written |
| wm_level | input | $clog2(DEPTH)+1 | Watermark level, 0..DEPTH |
| flag_clr | input | 3 | Write-one-to-clear: 0 underflow, 1 overflow, 2 swing-complete |
| int_en | input | 6 | Interrupt enables, order as in R12 |
| dma_en | input | 2 | DMA request enables: 0 empty, 1 watermark |
| conv_data | output | DATA_W | Sample presented to the converter |
| empty_flag | output | 1 | FIFO empty |
| full_flag | output | 1 | FIFO full |
| wm_flag | output | 1 | Count at or below watermark |
| uf_flag | output | 1 | Sticky underflow |
| of_flag | output | 1 | Sticky overflow |
| swbk_flag | output | 1 | Sticky swing period complete |
| irq | output | 1 | Interrupt request |
| dma_empty_req | output | 1 | DMA request on empty |
| dma_wm_req | output | 1 | DMA request on watermark |

## Verification
The hardest situation to reach is a swing sweep that changes shape while it runs. Writes during swing mode raise the top after the index has already turned downward. Because the level flags are frozen, the ports do not reveal the count. A directed sweep over three entries checks the exact index order and the completion trigger. A long random run then mixes writes, triggers, clears, mode changes and pointer resets, so that the top moves mid-sweep and near-full overflows occur during swing. Every cycle is compared against a bench model of the index walk.

// File: rtl/dsf_pkg.sv
package dsf_pkg;
    typedef enum logic [1:0] {
        MODE_BUFFER = 2'd0,
        MODE_NORMAL = 2'd1,
        MODE_SWING  = 2'd2,
        MODE_NORM_B = 2'd3
    } play_mode_e;

    typedef enum logic {
        SW_RISE = 1'b0,
        SW_FALL = 1'b1
    } swing_state_e;

    localparam int IE_FULL  = 0;
    localparam int IE_EMPTY = 1;
    localparam int IE_WM    = 2;
    localparam int IE_SWBK  = 3;
    localparam int IE_OF    = 4;
    localparam int IE_UF    = 5;
    localparam int IE_W     = 6;
endpackage

// File: rtl/dsf_store.sv
module dsf_store #(
    parameter int DATA_W = 12,
    parameter int DEPTH  = 16,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/dsf_swing_seq.sv
module dsf_swing_seq
    import dsf_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          step,
    input  logic [AW-1:0] top,
    output logic [AW-1:0] idx,
    output logic          wrap_o
);
    swing_state_e  state_q, state_d;
    logic [AW-1:0] idx_q, idx_d;
    logic          wrap_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SW_RISE;
            idx_q   <= '0;
        end else if (clr) begin
            state_q <= SW_RISE;
            idx_q   <= '0;
        end else if (step) begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        wrap_d  = 1'b0;
        unique case (state_q)
            SW_RISE: begin
                if (top == '0) begin
                    idx_d  = '0;
                    wrap_d = 1'b1;
                end else if (idx_q >= top) begin
                    idx_d = idx_q - AW'(1);
                    if (idx_q == AW'(1)) begin
                        wrap_d = 1'b1;
                    end else begin
                        state_d = SW_FALL;
                    end
                end else begin
                    idx_d = idx_q + AW'(1);
                end
            end
            SW_FALL: begin
                if (idx_q <= AW'(1)) begin
                    idx_d   = '0;
                    state_d = SW_RISE;
                    wrap_d  = 1'b1;
                end else begin
                    idx_d = idx_q - AW'(1);
                end
            end
            default: begin
                state_d = SW_RISE;
                idx_d   = '0;
            end
        endcase
    end

    assign idx    = idx_q;
    assign wrap_o = step & wrap_d & ~clr;

    // R6: a completed period leaves the index at zero
    a_r6_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> (idx_q == '0));

    // R6: the index never passes the top while stepping
    a_r6_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clr) |-> (idx_q <= top));
endmodule

// File: rtl/dsf_flags.sv
module dsf_flags
    import dsf_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PW   = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_all,
    input  logic          freeze,
    input  logic [PW-1:0] cnt_next,
    input  logic [PW-1:0] wm_level,
    input  logic          uf_set,
    input  logic          of_set,
    input  logic          sb_set,
    input  logic [2:0]    w1c,
    input  logic [IE_W-1:0] int_en,
    input  logic [1:0]    dma_en,
    output logic          empty_o,
    output logic          full_o,
    output logic          wm_o,
    output logic          uf_o,
    output logic          of_o,
    output logic          sb_o,
    output logic          irq_o,
    output logic          dma_empty_o,
    output logic          dma_wm_o
);
    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

    logic empty_q, full_q, wm_q, uf_q, of_q, sb_q;
    logic [IE_W-1:0] flag_vec;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            empty_q <= 1'b1;
            full_q  <= 1'b0;
            wm_q    <= 1'b1;
            uf_q    <= 1'b0;
            of_q    <= 1'b0;
            sb_q    <= 1'b0;
        end else if (clr_all) begin
            empty_q <= 1'b1;
            full_q  <= 1'b0;
            wm_q    <= 1'b1;
            uf_q    <= 1'b0;
            of_q    <= 1'b0;
            sb_q    <= 1'b0;
        end else begin
            if (!freeze) begin
                empty_q <= (cnt_next == '0);
                full_q  <= (cnt_next == DEPTH_P);
                wm_q    <= (cnt_next <= wm_level);
            end
            uf_q <= uf_set | (uf_q & ~w1c[0]);
            of_q <= of_set | (of_q & ~w1c[1]);
            sb_q <= sb_set | (sb_q & ~w1c[2]);
        end
    end

    always_comb begin
        flag_vec           = '0;
        flag_vec[IE_FULL]  = full_q;
        flag_vec[IE_EMPTY] = empty_q;
        flag_vec[IE_WM]    = wm_q;
        flag_vec[IE_SWBK]  = sb_q;
        flag_vec[IE_OF]    = of_q;
        flag_vec[IE_UF]    = uf_q;
    end

    assign empty_o     = empty_q;
    assign full_o      = full_q;
    assign wm_o        = wm_q;
    assign uf_o        = uf_q;
    assign of_o        = of_q;
    assign sb_o        = sb_q;
    assign irq_o       = |(flag_vec & int_en);
    assign dma_empty_o = empty_q & dma_en[0];
    assign dma_wm_o    = wm_q & dma_en[1];

    // R7: level flags hold across a clock spent in swing mode
    a_r7_levels_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(freeze) && !$past(clr_all))
            |-> $stable({empty_q, full_q, wm_q}));

    // R8: underflow stays until cleared
    a_r8_uf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (uf_q && !w1c[0] && !clr_all) |=> uf_q);

    // R8: overflow stays until cleared
    a_r8_of_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (of_q && !w1c[1] && !clr_all) |=> of_q);
endmodule

// File: rtl/dac_sample_fifo.sv
module dac_sample_fifo
    import dsf_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int DEPTH  = 16,
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              fifo_rst,
    input  logic [1:0]        mode,
    input  logic              trig_sel,
    input  logic              hw_trig,
    input  logic              sw_trig,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [PW-1:0]     wm_level,
    input  logic [2:0]        flag_clr,
    input  logic [5:0]        int_en,
    input  logic [1:0]        dma_en,
    output logic [DATA_W-1:0] conv_data,
    output logic              empty_flag,
    output logic              full_flag,
    output logic              wm_flag,
    output logic              uf_flag,
    output logic              of_flag,
    output logic              swbk_flag,
    output logic              irq,
    output logic              dma_empty_req,
    output logic              dma_wm_req
);
    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

    play_mode_e        mode_e;
    logic              is_buf, is_swing, trig, clr_all;
    logic [PW-1:0]     wptr_q, rptr_q, cnt, cnt_next;
    logic              cnt_zero, cnt_full;
    logic              wr_ok, of_set, rd_norm, uf_set, swing_step, sb_set;
    logic [AW-1:0]     sidx, top, raddr;
    logic [DATA_W-1:0] rdata, conv_q;

    assign mode_e   = play_mode_e'(mode);
    assign is_buf   = (mode_e == MODE_BUFFER);
    assign is_swing = (mode_e == MODE_SWING);
    assign trig     = trig_sel ? sw_trig : hw_trig;
    assign clr_all  = soft_rst | fifo_rst;

    assign cnt      = wptr_q - rptr_q;
    assign cnt_zero = (cnt == '0);
    assign cnt_full = (cnt == DEPTH_P);

    assign wr_ok      = wr_en & ~is_buf & ~cnt_full;
    assign of_set     = wr_en & ~is_buf & cnt_full;
    assign rd_norm    = trig & ~is_buf & ~is_swing & ~cnt_zero;
    assign uf_set     = trig & ~is_buf & cnt_zero;
    assign swing_step = trig & is_swing & ~cnt_zero;
    assign cnt_next   = cnt + PW'(wr_ok) - PW'(rd_norm);

    assign top   = AW'(cnt - PW'(1));
    assign raddr = rptr_q[AW-1:0] + (is_swing ? sidx : '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr_q <= '0;
            rptr_q <= '0;
        end else if (clr_all) begin
            wptr_q <= '0;
            rptr_q <= '0;
        end else begin
            if (wr_ok) wptr_q <= wptr_q + PW'(1);
            if (rd_norm) rptr_q <= rptr_q + PW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            conv_q <= '0;
        end else if (soft_rst) begin
            conv_q <= '0;
        end else if (fifo_rst) begin
            conv_q <= conv_q;
        end else if (is_buf && wr_en) begin
            conv_q <= wr_data;
        end else if (rd_norm || swing_step) begin
            conv_q <= rdata;
        end
    end

    dsf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) store_i (
        .clk   (clk),
        .we    (wr_ok & ~clr_all),
        .waddr (wptr_q[AW-1:0]),
        .wdata (wr_data),
        .raddr (raddr),
        .rdata (rdata)
    );

    dsf_swing_seq #(.AW(AW)) swing_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr_all | ~is_swing),
        .step   (swing_step),
        .top    (top),
        .idx    (sidx),
        .wrap_o (sb_set)
    );

    dsf_flags #(.DEPTH(DEPTH)) flags_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_all     (clr_all),
        .freeze      (is_swing),
        .cnt_next    (cnt_next),
        .wm_level    (wm_level),
        .uf_set      (uf_set),
        .of_set      (of_set),
        .sb_set      (sb_set),
        .w1c         (flag_clr),
        .int_en      (int_en),
        .dma_en      (dma_en),
        .empty_o     (empty_flag),
        .full_o      (full_flag),
        .wm_o        (wm_flag),
        .uf_o        (uf_flag),
        .of_o        (of_flag),
        .sb_o        (swbk_flag),
        .irq_o       (irq),
        .dma_empty_o (dma_empty_req),
        .dma_wm_o    (dma_wm_req)
    );

    assign conv_data = conv_q;

    // R4: a write into a full FIFO leaves the write pointer and raises overflow
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !is_buf && cnt_full && !clr_all) |=> ($stable(wptr_q) && of_flag));

    // R3: a trigger on an empty FIFO holds the output and raises underflow
    a_r3_underflow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && !is_buf && cnt_zero && !clr_all && !wr_en) |=> ($stable(conv_q) && uf_flag));

    // R1: buffer-mode writes reach the output on the next clock
    a_r1_buffer_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (is_buf && wr_en && !clr_all) |=> (conv_q == $past(wr_data)));
endmodule

// File: tb/dac_sample_fifo_tb_top.sv
`timescale 1ns/1ps
module dac_sample_fifo_tb_top;
    localparam int DW = 12;
    localparam int D  = 16;
    localparam int PW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          soft_rst = 0, fifo_rst = 0, trig_sel = 0, hw_trig = 0, sw_trig = 0, wr_en = 0;
    logic [1:0]    mode = 0;
    logic [DW-1:0] wr_data = 0;
    logic [PW-1:0] wm_level = 4;
    logic [2:0]    flag_clr = 0;
    logic [5:0]    int_en = 0;
    logic [1:0]    dma_en = 0;
    logic [DW-1:0] conv_data;
    logic empty_flag, full_flag, wm_flag, uf_flag, of_flag, swbk_flag, irq, dma_empty_req, dma_wm_req;

    dac_sample_fifo #(.DATA_W(DW), .DEPTH(D)) dut_i (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .fifo_rst(fifo_rst), .mode(mode),
        .trig_sel(trig_sel), .hw_trig(hw_trig), .sw_trig(sw_trig), .wr_en(wr_en),
        .wr_data(wr_data), .wm_level(wm_level), .flag_clr(flag_clr), .int_en(int_en),
        .dma_en(dma_en), .conv_data(conv_data), .empty_flag(empty_flag), .full_flag(full_flag),
        .wm_flag(wm_flag), .uf_flag(uf_flag), .of_flag(of_flag), .swbk_flag(swbk_flag),
        .irq(irq), .dma_empty_req(dma_empty_req), .dma_wm_req(dma_wm_req)
    );

    always #10 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // bench model
    int            mw, mr, msidx;
    bit            mfall;
    logic [DW-1:0] mmem [D];
    logic [DW-1:0] mconv;
    bit            muf, mof, msb, mempty, mfull, mwm;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit model_irq();
        bit [5:0] v;
        v = {muf, mof, msb, mwm, mempty, mfull};
        return |(v & int_en);
    endfunction

    task automatic model_clear_fifo();
        mw = 0; mr = 0; msidx = 0; mfall = 0;
        muf = 0; mof = 0; msb = 0;
        mempty = 1; mfull = 0; mwm = 1;
    endtask

    task automatic model_step();
        int  cnt, top, nc;
        bit  trg, uf_e, of_e, sb_e, sw;
        if (soft_rst) begin
            model_clear_fifo();
            mconv = 0;
            return;
        end
        if (fifo_rst) begin
            model_clear_fifo();
            return;
        end
        cnt = mw - mr;
        trg = trig_sel ? sw_trig : hw_trig;
        sw  = (mode == 2);
        uf_e = 0; of_e = 0; sb_e = 0;
        if (mode == 0) begin
            if (wr_en) mconv = wr_data;
        end else begin
            if (trg) begin
                if (cnt == 0) uf_e = 1;
                else if (!sw) begin
                    mconv = mmem[mr % D];
                    mr++;
                end else begin
                    mconv = mmem[(mr + msidx) % D];
                    top = cnt - 1;
                    if (!mfall) begin
                        if (top == 0) begin msidx = 0; sb_e = 1; end
                        else if (msidx >= top) begin
                            msidx--;
                            if (msidx == 0) sb_e = 1; else mfall = 1;
                        end else msidx++;
                    end else begin
                        msidx--;
                        if (msidx <= 0) begin msidx = 0; mfall = 0; sb_e = 1; end
                    end
                end
            end
            if (wr_en) begin
                if (cnt == D) of_e = 1;
                else begin
                    mmem[mw % D] = wr_data;
                    mw++;
                end
            end
        end
        if (!sw) begin msidx = 0; mfall = 0; end
        muf = uf_e | (muf & !flag_clr[0]);
        mof = of_e | (mof & !flag_clr[1]);
        msb = sb_e | (msb & !flag_clr[2]);
        if (!sw) begin
            nc = mw - mr;
            mempty = (nc == 0);
            mfull  = (nc == D);
            mwm    = (nc <= int'(wm_level));
        end
    endtask

    task automatic compare_all();
        chk("R2 conv_data", conv_data, mconv);
        chk("R5 empty_flag", empty_flag, mempty);
        chk("R5 full_flag", full_flag, mfull);
        chk("R5 wm_flag", wm_flag, mwm);
        chk("R3 uf_flag", uf_flag, muf);
        chk("R4 of_flag", of_flag, mof);
        chk("R6 swbk_flag", swbk_flag, msb);
        chk("R12 irq", irq, model_irq());
        chk("R12 dma_empty_req", dma_empty_req, mempty & dma_en[0]);
        chk("R12 dma_wm_req", dma_wm_req, mwm & dma_en[1]);
    endtask

    // inputs already set at a falling edge: advance one clock and compare
    task automatic tick();
        model_step();
        @(negedge clk);
        compare_all();
        hw_trig = 0; sw_trig = 0; wr_en = 0; flag_clr = 0; fifo_rst = 0; soft_rst = 0;
    endtask

    task automatic do_write(input logic [DW-1:0] d);
        wr_en = 1; wr_data = d; tick();
    endtask

    task automatic do_trig(input bit use_sw);
        if (use_sw) sw_trig = 1; else hw_trig = 1;
        tick();
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd24681);
        model_clear_fifo();
        mconv = 0;
        for (int i = 0; i < D; i++) mmem[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        compare_all();
        chk("R11 reset conv", conv_data, 0);
        chk("R11 reset empty", empty_flag, 1);

        // R1 buffer mode
        mode = 0;
        do_write(12'hABC);
        chk("R1 buffer write", conv_data, 12'hABC);
        do_trig(0);
        chk("R1 trigger ignored", conv_data, 12'hABC);
        chk("R1 no underflow", uf_flag, 0);

        // R2/R4/R5 normal mode fill
        mode = 1; wm_level = 4; int_en = 6'b010000; dma_en = 2'b11;
        for (int i = 0; i < D; i++) begin
            do_write(DW'(100 + i));
            if (i == 3) chk("R5 wm at level", wm_flag, 1);
            if (i == 4) chk("R5 wm above level", wm_flag, 0);
        end
        chk("R5 full", full_flag, 1);
        do_write(12'h777);
        chk("R4 overflow flag", of_flag, 1);
        chk("R12 irq on overflow", irq, 1);
        flag_clr = 3'b010; tick();
        chk("R8 overflow cleared", of_flag, 0);
        for (int i = 0; i < D; i++) begin
            do_trig(0);
            chk("R2 order", conv_data, 100 + i);
        end
        chk("R4 dropped data absent", empty_flag, 1);
        do_trig(0);
        chk("R3 underflow set", uf_flag, 1);
        chk("R3 output held", conv_data, 115);
        tick();
        chk("R8 underflow sticky", uf_flag, 1);
        flag_clr = 3'b001; hw_trig = 1; tick();
        chk("R8 set wins over clear", uf_flag, 1);
        flag_clr = 3'b001; tick();
        chk("R8 underflow cleared", uf_flag, 0);

        // R9 trigger select
        trig_sel = 1;
        do_write(12'h011); do_write(12'h022);
        do_trig(0);
        chk("R9 hw ignored under sw select", conv_data, 115);
        do_trig(1);
        chk("R9 sw trigger", conv_data, 12'h011);
        trig_sel = 0;
        do_trig(1);
        chk("R9 sw ignored under hw select", conv_data, 12'h011);

        // R10 fifo reset
        fifo_rst = 1; tick();
        chk("R10 empty after fifo reset", empty_flag, 1);
        chk("R10 conv kept", conv_data, 12'h011);

        // R6/R7 swing over three entries
        mode = 2;
        do_write(12'h0A0); do_write(12'h0A1); do_write(12'h0A2);
        chk("R7 empty frozen", empty_flag, 1);
        begin
            int exp_seq [7] = '{12'h0A0, 12'h0A1, 12'h0A2, 12'h0A1, 12'h0A0, 12'h0A1, 12'h0A2};
            for (int k = 0; k < 7; k++) begin
                do_trig(0);
                chk("R6 swing order", conv_data, exp_seq[k]);
                if (k == 2) chk("R6 no flag before period", swbk_flag, 0);
                if (k == 3) chk("R6 flag on 4th trigger", swbk_flag, 1);
            end
        end
        flag_clr = 3'b100; tick();
        chk("R8 swing flag cleared", swbk_flag, 0);

        // R11 soft reset
        soft_rst = 1; fifo_rst = 1; tick();
        chk("R11 soft reset conv", conv_data, 0);

        // random phase
        for (int n = 0; n < 5000; n++) begin
            if ($urandom_range(99) < 3) mode = 2'($urandom_range(3));
            if ($urandom_range(99) < 5) trig_sel = 1'($urandom_range(1));
            if ($urandom_range(99) < 5) wm_level = PW'($urandom_range(D));
            if ($urandom_range(99) < 5) int_en = 6'($urandom);
            if ($urandom_range(99) < 5) dma_en = 2'($urandom);
            hw_trig  = ($urandom_range(99) < 40);
            sw_trig  = ($urandom_range(99) < 40);
            wr_en    = ($urandom_range(99) < 45);
            wr_data  = DW'($urandom);
            flag_clr = ($urandom_range(99) < 10) ? 3'($urandom) : 3'b0;
            fifo_rst = ($urandom_range(999) < 8);
            soft_rst = ($urandom_range(999) < 4);
            tick();
        end
        done = 1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule